// File: doc/BRIEF.md
# Serial Delay Configuration Receiver

This block is the receive end of a three-wire serial configuration port for a delay-select stage. A serial clock shifts one data bit per rising edge into an 11-bit shift register. A separate load strobe moves the shift contents into a holding latch. The latch drives the decoded configuration: a phase select bit, a mode select bit and a 9-bit delay code. The delay-select logic downstream uses these fields.

Loading takes both edges of one strobe. When the strobe rises, the latch takes the shift contents. While the strobe stays high, the latch follows the shift register. When the strobe falls, the latch value is frozen. Bits arrive least significant first: the phase bit first, then the mode bit, then the delay bits from lowest to highest. A sticky flag records any load strobe that did not follow exactly 11 serial clocks.

All three serial inputs are resynchronised to one system clock and edge-detected there. No derived clocks are used.

Top module: `serial_delay_cfg`

## Requirements
- R1: After 11 serial bits and a load strobe, the outputs hold these values: `phase_sel` is the first bit sent, `mode_sel` is the second bit, and `delay_code[k]` is bit k+2 of the sequence (the last bit sent is `delay_code[8]`, the most significant bit).
- R2: While the load strobe is low, shifting new bits leaves `phase_sel`, `mode_sel` and `delay_code` unchanged.
- R3: A rising edge of the load strobe copies the current shift register contents to the outputs.
- R4: While the load strobe is high, further serial bits update the outputs. The value present at the falling edge is retained.
- R5: After the load strobe falls, later serial bits do not change the outputs.
- R6: Reset clears the outputs to zero and clears `count_err`.
- R7: `count_err` goes to 1 when the load strobe rises after a number of serial clocks other than 11, counted since the previous strobe fall or reset. It then stays at 1 until reset.
- R8: A load strobe that follows exactly 11 serial clocks leaves `count_err` at 0. The count restarts from zero at each strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; data is shifted on its rising edge |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Load strobe; rising edge copies, falling edge freezes |
| phase_sel | output | 1 | Decoded phase select bit |
| mode_sel | output | 1 | Decoded mode select bit |
| delay_code | output | 9 | Decoded delay value |
| count_err | output | 1 | Sticky flag for a load after a bit count other than 11 |

## Verification
Words with a single bit set, each in the phase, mode or top delay position, show whether the field order and the LSB-first shifting are right. Randomly drawn words compare the full mapping, and the outputs are checked both before and after each strobe. This separates a latch that holds from one that follows the shift register. Extra bits shifted while the strobe is high, and again after it falls, tell a transparent latch apart from an edge-only copy and from a latch that never freezes. Loads after 10, 11 and 12 clocks exercise the exact-count rule and show that the error flag is sticky.

// File: rtl/serial_delay_cfg.sv
module serial_delay_cfg #(
  parameter int WORD_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  output logic              phase_sel,
  output logic              mode_sel,
  output logic [WORD_W-3:0] delay_code,
  output logic              count_err
);
  localparam int CNT_W = $clog2(WORD_W + 2) + 1;

  logic [SYNC_STAGES-1:0] clk_sync, dat_sync, ld_sync;
  logic                   clk_prev, ld_prev;
  logic                   clk_now, dat_now, ld_now;
  logic                   sclk_rise, ld_rise, ld_fall;
  logic [WORD_W-1:0]      shreg, shreg_nxt, latch;
  logic [CNT_W-1:0]       cnt, cnt_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= '0;
      dat_sync <= '0;
      ld_sync  <= '0;
      clk_prev <= 1'b0;
      ld_prev  <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], ser_clk};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], ser_data};
      ld_sync  <= {ld_sync[SYNC_STAGES-2:0], ser_load};
      clk_prev <= clk_now;
      ld_prev  <= ld_now;
    end
  end

  assign clk_now   = clk_sync[SYNC_STAGES-1];
  assign dat_now   = dat_sync[SYNC_STAGES-1];
  assign ld_now    = ld_sync[SYNC_STAGES-1];
  assign sclk_rise = clk_now & ~clk_prev;
  assign ld_rise   = ld_now & ~ld_prev;
  assign ld_fall   = ld_prev & ~ld_now;

  assign shreg_nxt = sclk_rise ? {dat_now, shreg[WORD_W-1:1]} : shreg;
  assign cnt_inc   = (sclk_rise && cnt != '1) ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      latch     <= '0;
      cnt       <= '0;
      count_err <= 1'b0;
    end else begin
      shreg <= shreg_nxt;
      if (ld_now || ld_prev) latch <= shreg_nxt;
      cnt <= ld_fall ? '0 : cnt_inc;
      if (ld_rise && cnt_inc != CNT_W'(WORD_W)) count_err <= 1'b1;
    end
  end

  assign phase_sel  = latch[0];
  assign mode_sel   = latch[1];
  assign delay_code = latch[WORD_W-1:2];
endmodule

// File: rtl/serial_delay_cfg_chk.sv
module serial_delay_cfg_chk #(
  parameter int WORD_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_now,
  input logic              ld_prev,
  input logic              sclk_rise,
  input logic [WORD_W-1:0] shreg,
  input logic [WORD_W-1:0] latch,
  input logic              count_err,
  input logic [$clog2(WORD_W + 2):0] cnt
);
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_now && !ld_prev) |=> $stable(latch)); // R2

  AST_COPY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_now && !ld_prev && !sclk_rise) |=> latch == $past(shreg)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    count_err |=> count_err); // R7

  AST_ERR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_err) |-> $past(ld_now && !ld_prev)); // R7

  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_prev && !ld_now) |=> cnt == '0); // R8
endmodule

bind serial_delay_cfg serial_delay_cfg_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/test_serial_delay_cfg.sv
module test_serial_delay_cfg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic       phase_sel, mode_sel, count_err;
  logic [8:0] delay_code;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [10:0] model = '0;

  always #4 clk = ~clk;

  serial_delay_cfg i_serial_delay_cfg (.*);

  function automatic logic [10:0] outs();
    return {delay_code, mode_sel, phase_sel};
  endfunction

  function automatic logic [10:0] shift_model(logic [10:0] m, logic b);
    return {b, m[10:1]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    ser_data = b; wait_cyc(4);
    ser_clk = 1'b1; wait_cyc(4);
    ser_clk = 1'b0; wait_cyc(4);
    model = shift_model(model, b);
  endtask

  task automatic send_word(logic [10:0] w, int n);
    for (int i = 0; i < n; i++) send_bit(w[i]);
  endtask

  task automatic load();
    ser_load = 1'b1; wait_cyc(8);
    ser_load = 1'b0; wait_cyc(8);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wait_cyc(3);
    rst_n = 1'b1; wait_cyc(3);
    model = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [10:0] w, held;
    void'($urandom(32'h5eed));
    do_reset();
    check("R6 outputs after reset", outs(), 11'h000);
    check("R6 count_err after reset", count_err, 0);

    send_word(11'h001, 11); load();
    check("R1 phase bit first", outs(), 11'h001);
    check("R1 phase_sel", phase_sel, 1);
    send_word(11'h002, 11); load();
    check("R1 mode_sel second", mode_sel, 1);
    check("R1 phase cleared", phase_sel, 0);
    send_word(11'h400, 11); load();
    check("R1 last bit is delay MSB", delay_code, 9'h100);
    check("R8 exact count no error", count_err, 0);

    for (int k = 0; k < 16; k++) begin
      w = 11'($urandom);
      held = outs();
      send_word(w, 11);
      check("R2 hold while strobe low", outs(), held);
      load();
      check("R1 R3 random word loaded", outs(), w);
      check("R1 delay field", delay_code, w[10:2]);
    end
    check("R8 no error after good loads", count_err, 0);

    w = 11'($urandom);
    send_word(w, 11);
    ser_load = 1'b1; wait_cyc(8);
    check("R3 copy on rising edge", outs(), w);
    send_word(11'h005, 3);
    wait_cyc(4);
    check("R4 transparent while high", outs(), model);
    held = model;
    ser_load = 1'b0; wait_cyc(8);
    check("R4 value kept at fall", outs(), held);
    send_word(11'h1f, 5);
    check("R5 frozen after fall", outs(), held);

    do_reset();
    send_word(11'h3ff, 10); load();
    check("R7 ten clocks sets error", count_err, 1);
    send_word(11'h155, 11); load();
    check("R7 error sticky", count_err, 1);
    check("R3 load still copies", outs(), 11'h155);
    do_reset();
    check("R6 reset clears error", count_err, 0);
    send_word(11'h2aa, 11); send_bit(1'b1); load();
    check("R7 twelve clocks sets error", count_err, 1);
    do_reset();
    send_word(11'h0f0, 11); load();
    send_word(11'h00f, 11); load();
    check("R8 count restarts at fall", count_err, 0);
    check("R1 second word", outs(), 11'h00f);

    finish_run();
  end
endmodule